// File: doc/BRIEF.md
# Sampled Fixed-Point PID Controller with Integrator Clamp

This block closes a control loop in integer-only logic. A programmable prescaler derives a slow sample strobe from the fast system clock. On each strobe the block forms the error between a signed setpoint and a signed measurement. From that error it computes a proportional, an integral and a derivative contribution using signed Q8.8 gains. It then adds the three and saturates the sum to a programmable window. The result is registered and announced by a one-cycle valid pulse.

Running the update on every system clock would make the integrator grow far too fast. The prescaler therefore sets the loop rate, which is typically tens of kilohertz. The integral path gets extra fractional resolution from a programmable power-of-two right shift, so gains well below one least-significant Q8.8 step are usable. The accumulator has its own symmetric clamp, separate from the output saturation, so that it cannot wind up while the output is pinned.

Top module: `fxp_pid_ctrl`

## Requirements
- R1: The sample strobe repeats every `div_cfg` clock cycles and lasts one cycle; a `div_cfg` of 0 behaves as 1, so the strobe is then present on every cycle.
- R2: The error is `setpoint - measure`, taken at 17 bits with no wrap. The proportional term is `(kp * error) >>> 8`, where `kp` is a signed two's-complement Q8.8 gain (bits 15:8 integer, bits 7:0 fraction).
- R3: On each strobe the accumulator adds `(ki * error) >>> (8 + ki_shift)`, where `ki` is signed Q8.8 and `ki_shift` is 0..15 and the shift is arithmetic, rounding toward minus infinity. The accumulator value after that update is the integral term. Between strobes the accumulator holds.
- R4: After every update the accumulator is clamped to `[-int_lim, +int_lim]`, with `int_lim` an unsigned 24-bit value. An `int_lim` of 0 keeps the integral term at 0.
- R5: The derivative term is `(kd * (error - prev_error)) >>> 8`, with `kd` signed Q8.8. The stored previous error is updated only on strobes and is 0 after reset. Input values between strobes have no effect.
- R6: The output is the 40-bit sum P+I+D saturated as follows. If the sum is above `out_hi` the output is `out_hi`. Otherwise, if the sum is below `out_lo`, the output is `out_lo`. Otherwise the output is the sum. The upper bound is tested first.
- R7: `ctrl_out` and `out_valid` change on the clock edge that ends the strobe cycle. `out_valid` is high for exactly that one following cycle, and `ctrl_out` holds its value until the next update.
- R8: A synchronous active-low reset clears the integrator, the stored previous error, `ctrl_out` and `out_valid`.
- R9: Changing `kp`, `ki`, `kd`, `ki_shift` or the bounds does not clear the accumulator; the next update continues from its held value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_cfg | input | 16 | Sample period in clock cycles (0 treated as 1) |
| kp | input | 16 | Proportional gain, signed Q8.8 |
| ki | input | 16 | Integral gain, signed Q8.8 |
| kd | input | 16 | Derivative gain, signed Q8.8 |
| ki_shift | input | 4 | Extra right shift applied to the integral increment |
| int_lim | input | 24 | Unsigned magnitude limit of the accumulator |
| out_hi | input | 16 | Signed upper output bound |
| out_lo | input | 16 | Signed lower output bound |
| setpoint | input | 16 | Signed target value |
| measure | input | 16 | Signed measured value |
| ctrl_out | output | 16 | Registered signed control output |
| out_valid | output | 1 | One-cycle pulse marking a new `ctrl_out` |

## Verification
The hardest state to reach from the ports is an accumulator that sits at its clamp and must then unwind. Reaching it also requires the floor rounding of negative increments under every shift amount. The stimulus uses a small limit with a large integral gain to pin the accumulator at both signs, then reverses the error to pull it back. It also sweeps all sixteen shift values with positive and negative errors. The derivative path is tested by changing the inputs to unrelated values between strobes, which shows that only the values present at a strobe reach the stored error.

// File: rtl/fxp_pid_pkg.sv
// Shared sizing for the sampled PID controller.
// Assumes 16-bit signed samples and Q8.8 gains; sums carry 40 bits.
package fxp_pid_pkg;
    localparam int PID_IN_W   = 16;
    localparam int PID_GAIN_W = 16;
    localparam int PID_FRAC_W = 8;
    localparam int PID_SUM_W  = 40;
    localparam int PID_LIM_W  = 24;
    localparam int PID_SH_W   = 4;
    localparam int PID_DIV_W  = 16;
endpackage

// File: rtl/pid_prescaler.sv
// Sample-strobe generator: pulses stb for one cycle every div_cfg cycles.
// Assumes div_cfg may change at any time; a value of 0 acts as 1.
module pid_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_cfg,
    output logic             stb
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff_div;
    logic             wrap;

    // Effective period and the end-of-period condition.
    always_comb begin
        eff_div = (div_cfg == '0) ? DIV_W'(1) : div_cfg;
        wrap    = (cnt_q >= eff_div - DIV_W'(1));
    end

    // Count cycles and emit the registered strobe at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            stb   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            stb   <= 1'b1;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
            stb   <= 1'b0;
        end
    end

    // R1: with a period above one the strobe never lasts two cycles.
    p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && eff_div > DIV_W'(1)) |=> !stb);
endmodule

// File: rtl/pid_integrator.sv
// Integral path: adds (ki*err) >>> (FRAC+shift) on each enable and
// clamps the accumulator to +/- lim. acc_next is the post-update value
// for use in the same cycle. Assumes lim is an unsigned magnitude.
module pid_integrator #(
    parameter int ERR_W  = 17,
    parameter int GAIN_W = 16,
    parameter int FRAC_W = 8,
    parameter int SH_W   = 4,
    parameter int LIM_W  = 24,
    parameter int SUM_W  = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [GAIN_W-1:0] ki,
    input  logic [SH_W-1:0]         shift,
    input  logic [LIM_W-1:0]        lim,
    output logic signed [SUM_W-1:0] acc_next
);
    logic signed [SUM_W-1:0] acc_q, prod, incr, raw, lim_pos, lim_neg;

    // Scaled increment, raw sum and symmetric clamp.
    always_comb begin
        prod    = SUM_W'(ki) * SUM_W'(err);
        incr    = prod >>> (FRAC_W + int'(shift));
        raw     = acc_q + incr;
        lim_pos = $signed({{(SUM_W-LIM_W){1'b0}}, lim});
        lim_neg = -lim_pos;
        if (raw > lim_pos)      acc_next = lim_pos;
        else if (raw < lim_neg) acc_next = lim_neg;
        else                    acc_next = raw;
    end

    // Accumulator register, written only on sample strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_next;
    end

    // R4: after an update the stored value lies within the limit in force.
    p_acc_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (acc_q <= $past(lim_pos)) && (acc_q >= $past(lim_neg)));
    // R3: without a strobe the accumulator holds.
    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));
endmodule

// File: rtl/pid_deriv.sv
// Derivative path: kd times the change in error since the last strobe,
// rescaled from Q8.8. Assumes err is valid whenever en is high.
module pid_deriv #(
    parameter int ERR_W  = 17,
    parameter int GAIN_W = 16,
    parameter int FRAC_W = 8,
    parameter int SUM_W  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic signed [ERR_W-1:0]  err,
    input  logic signed [GAIN_W-1:0] kd,
    output logic signed [SUM_W-1:0]  d_term
);
    logic signed [ERR_W-1:0] prev_q;
    logic signed [SUM_W-1:0] delta;

    // Error difference and scaled product.
    always_comb begin
        delta  = SUM_W'(err) - SUM_W'(prev_q);
        d_term = (SUM_W'(kd) * delta) >>> FRAC_W;
    end

    // Keep the error seen at the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  prev_q <= '0;
        else if (en) prev_q <= err;
    end

    // R5: the stored error changes only on strobes, and then to the sampled error.
    p_prev_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(prev_q));
    p_prev_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> prev_q == $past(err));
endmodule

// File: rtl/pid_out_stage.sv
// Output stage: sums P, I and D, saturates (upper bound tested first)
// and registers the result with a one-cycle valid pulse.
module pid_out_stage #(
    parameter int OUT_W = 16,
    parameter int SUM_W = 40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [SUM_W-1:0] p_term,
    input  logic signed [SUM_W-1:0] i_term,
    input  logic signed [SUM_W-1:0] d_term,
    input  logic signed [OUT_W-1:0] out_hi,
    input  logic signed [OUT_W-1:0] out_lo,
    output logic signed [OUT_W-1:0] ctrl_out,
    output logic                    out_valid
);
    logic signed [SUM_W-1:0] total;
    logic signed [OUT_W-1:0] sat_val;

    // Sum and saturate.
    always_comb begin
        total = p_term + i_term + d_term;
        if (total > SUM_W'(out_hi))      sat_val = out_hi;
        else if (total < SUM_W'(out_lo)) sat_val = out_lo;
        else                             sat_val = OUT_W'(total);
    end

    // Register the output and flag each fresh result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_out  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= en;
            if (en) ctrl_out <= sat_val;
        end
    end

    // R7: valid follows the strobe by one cycle.
    p_valid_after_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> out_valid);
    p_valid_only_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_valid);
    p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ctrl_out));
    // R6: with an ordered window the output stays inside it.
    p_out_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out_lo <= out_hi) |=> (ctrl_out <= $past(out_hi)) && (ctrl_out >= $past(out_lo)));
endmodule

// File: rtl/fxp_pid_ctrl.sv
// Top level of the sampled fixed-point PID controller.
// Assumes all configuration inputs are quasi-static relative to the
// sample period; setpoint and measure are sampled on the strobe cycle.
module fxp_pid_ctrl
    import fxp_pid_pkg::*;
#(
    parameter int IN_W   = PID_IN_W,
    parameter int GAIN_W = PID_GAIN_W,
    parameter int FRAC_W = PID_FRAC_W,
    parameter int SUM_W  = PID_SUM_W,
    parameter int LIM_W  = PID_LIM_W,
    parameter int SH_W   = PID_SH_W,
    parameter int DIV_W  = PID_DIV_W,
    parameter int OUT_W  = PID_IN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DIV_W-1:0]         div_cfg,
    input  logic signed [GAIN_W-1:0] kp,
    input  logic signed [GAIN_W-1:0] ki,
    input  logic signed [GAIN_W-1:0] kd,
    input  logic [SH_W-1:0]          ki_shift,
    input  logic [LIM_W-1:0]         int_lim,
    input  logic signed [OUT_W-1:0]  out_hi,
    input  logic signed [OUT_W-1:0]  out_lo,
    input  logic signed [IN_W-1:0]   setpoint,
    input  logic signed [IN_W-1:0]   measure,
    output logic signed [OUT_W-1:0]  ctrl_out,
    output logic                     out_valid
);
    localparam int ERR_W = IN_W + 1;

    logic                    samp_stb;
    logic signed [ERR_W-1:0] err;
    logic signed [SUM_W-1:0] p_term, i_term, d_term;

    // Widened error and proportional term.
    always_comb begin
        err    = ERR_W'(setpoint) - ERR_W'(measure);
        p_term = (SUM_W'(kp) * SUM_W'(err)) >>> FRAC_W;
    end

    pid_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .stb(samp_stb)
    );

    pid_integrator #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W),
        .SH_W(SH_W), .LIM_W(LIM_W), .SUM_W(SUM_W)
    ) u_integ (
        .clk(clk), .rst_n(rst_n), .en(samp_stb), .err(err), .ki(ki),
        .shift(ki_shift), .lim(int_lim), .acc_next(i_term)
    );

    pid_deriv #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W), .SUM_W(SUM_W)
    ) u_deriv (
        .clk(clk), .rst_n(rst_n), .en(samp_stb), .err(err), .kd(kd),
        .d_term(d_term)
    );

    pid_out_stage #(.OUT_W(OUT_W), .SUM_W(SUM_W)) u_out (
        .clk(clk), .rst_n(rst_n), .en(samp_stb), .p_term(p_term),
        .i_term(i_term), .d_term(d_term), .out_hi(out_hi), .out_lo(out_lo),
        .ctrl_out(ctrl_out), .out_valid(out_valid)
    );

    // R8: the cycle after reset is asserted the output is cleared.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (ctrl_out == '0) && !out_valid);
endmodule

// File: tb/fxp_pid_ctrl_tb.sv
`timescale 1ns/1ps
module fxp_pid_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] div_cfg = 16'd4;
    logic signed [15:0] kp = '0, ki = '0, kd = '0;
    logic [3:0] ki_shift = '0;
    logic [23:0] int_lim = '0;
    logic signed [15:0] out_hi = 16'sd32767, out_lo = -16'sd32768;
    logic signed [15:0] setpoint = '0, measure = '0;
    logic signed [15:0] ctrl_out;
    logic out_valid;

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 1'b0;

    longint m_acc = 0;
    longint m_prev = 0;
    longint exp_out = 0;

    always #2 clk = ~clk;

    fxp_pid_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .kp(kp), .ki(ki), .kd(kd),
        .ki_shift(ki_shift), .int_lim(int_lim), .out_hi(out_hi), .out_lo(out_lo),
        .setpoint(setpoint), .measure(measure), .ctrl_out(ctrl_out), .out_valid(out_valid)
    );

    task automatic check(input string tag, input longint got, input longint expv);
        n_checks++;
        if (got != expv) begin
            n_errs++;
            $display("FAIL %s: got %0d expected %0d", tag, got, expv);
        end
    endtask

    // Model step from the requirements (R2..R6).
    task automatic model_step(input longint sp, input longint ms);
        longint e, p, inc, d, s;
        e = sp - ms;
        p = (longint'(kp) * e) >>> 8;
        inc = (longint'(ki) * e) >>> (8 + int'(ki_shift));
        m_acc = m_acc + inc;
        if (m_acc > longint'(int_lim)) m_acc = longint'(int_lim);
        else if (m_acc < -longint'(int_lim)) m_acc = -longint'(int_lim);
        d = (longint'(kd) * (e - m_prev)) >>> 8;
        m_prev = e;
        s = p + m_acc + d;
        if (s > longint'(out_hi)) exp_out = longint'(out_hi);
        else if (s < longint'(out_lo)) exp_out = longint'(out_lo);
        else exp_out = s;
    endtask

    // R8: synchronous reset, outputs checked while it is held.
    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({tag, " reset out"}, longint'(ctrl_out), 0);
        check({tag, " reset valid"}, longint'(out_valid), 0);
        m_acc = 0;
        m_prev = 0;
        rst_n = 1'b1;
    endtask

    // One sample: optional unrelated values first, then the real inputs.
    task automatic do_sample(input longint sp, input longint ms, input bit glitch, input string tag);
        int waited;
        if (glitch) begin
            setpoint = 16'(-sp + 77);
            measure = 16'(ms - 1111);
            @(negedge clk);
        end
        setpoint = 16'(sp);
        measure = 16'(ms);
        model_step(sp, ms);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!out_valid && waited < 100);
        if (!out_valid) begin
            n_checks++;
            n_errs++;
            $display("FAIL %s: no out_valid (R7) got 0 expected 1", tag);
        end
        check(tag, longint'(ctrl_out), exp_out);
        // R7: pulse lasts one cycle, output held.
        @(negedge clk);
        check({tag, " R7 pulse"}, longint'(out_valid), 0);
        check({tag, " R7 hold"}, longint'(ctrl_out), exp_out);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        longint sps[5] = '{-3000, -1, 0, 1, 32767};
        longint mss[3] = '{0, 1234, -32768};
        logic signed [15:0] kps[4] = '{16'sh0100, 16'sh0180, 16'shFF80, 16'sh7FFF};
        int cnt;

        @(negedge clk);
        do_reset("R8 initial");

        // R1: pulse count over a 60-cycle window for several periods.
        for (int dv = 0; dv <= 6; dv++) begin
            int eff;
            div_cfg = 16'(dv);
            eff = (dv == 0) ? 1 : dv;
            repeat (40) @(negedge clk);
            cnt = 0;
            for (int c = 0; c < 60; c++) begin
                if (out_valid) cnt++;
                @(negedge clk);
            end
            check($sformatf("R1 period div=%0d", dv), cnt, 60 / eff);
        end

        div_cfg = 16'd4;
        @(negedge clk);
        do_reset("R8 before sweep");

        // R2: proportional sweep.
        ki = '0; kd = '0; int_lim = 24'hFFFFFF;
        foreach (kps[g]) begin
            kp = kps[g];
            foreach (sps[i]) foreach (mss[j])
                do_sample(sps[i], mss[j], 1'b0, $sformatf("R2 kp=%0d", kps[g]));
        end

        // R3: integral shift sweep, positive and negative errors.
        kp = '0;
        ki = 16'sh0300;
        for (int n = 0; n < 16; n++) begin
            do_reset("R3 pre");
            ki_shift = 4'(n);
            do_sample(1000, 0, 1'b0, $sformatf("R3 n=%0d a", n));
            do_sample(1000, 0, 1'b0, $sformatf("R3 n=%0d b", n));
            do_sample(-700, 0, 1'b0, $sformatf("R3 n=%0d c", n));
            do_sample(0, 3, 1'b0, $sformatf("R3 n=%0d d", n));
        end

        // R4: clamp at both signs and unwinding.
        do_reset("R4 pre");
        ki = 16'sh1000; ki_shift = 4'd0; int_lim = 24'd5000;
        do_sample(2000, 0, 1'b0, "R4 pos clamp");
        do_sample(2000, 0, 1'b0, "R4 pos clamp hold");
        do_sample(0, 2000, 1'b0, "R4 neg clamp");
        do_sample(10, 0, 1'b0, "R4 unwind");
        int_lim = 24'd0;
        do_sample(2000, 0, 1'b0, "R4 zero limit");

        // R5: derivative with unrelated inputs between strobes.
        do_reset("R5 pre");
        ki = '0; kd = 16'sh0200; int_lim = 24'hFFFFFF;
        do_sample(100, 0, 1'b1, "R5 first");
        do_sample(400, 0, 1'b1, "R5 rise");
        do_sample(-300, 0, 1'b1, "R5 fall");
        do_sample(-300, 0, 1'b1, "R5 flat");
        do_sample(32767, -32768, 1'b1, "R5 step");

        // R6: narrow window, and crossed bounds (upper tested first).
        do_reset("R6 pre");
        kd = '0; kp = 16'sh0100;
        out_hi = 16'sd500; out_lo = -16'sd200;
        do_sample(1000, 0, 1'b0, "R6 above");
        do_sample(-1000, 0, 1'b0, "R6 below");
        do_sample(300, 0, 1'b0, "R6 inside");
        do_sample(500, 0, 1'b0, "R6 at hi");
        do_sample(501, 0, 1'b0, "R6 hi+1");
        do_sample(-200, 0, 1'b0, "R6 at lo");
        do_sample(-201, 0, 1'b0, "R6 lo-1");
        out_hi = -16'sd10; out_lo = 16'sd10;
        do_sample(0, 0, 1'b0, "R6 crossed");
        out_hi = 16'sd32767; out_lo = -16'sd32768;

        // R9: gain change keeps the accumulator.
        do_reset("R9 pre");
        kp = 16'sh0080; ki = 16'sh0100; kd = 16'sh0040;
        do_sample(500, 0, 1'b0, "R9 build a");
        do_sample(500, 0, 1'b0, "R9 build b");
        kp = 16'sh0200; kd = '0; ki = 16'sh0080; ki_shift = 4'd2;
        do_sample(500, 0, 1'b0, "R9 after change");
        do_sample(0, 0, 1'b0, "R9 held acc");

        // R8: reset mid-run clears integrator and previous error.
        do_reset("R8 mid");
        kd = 16'sh0100;
        do_sample(0, 0, 1'b0, "R8 after reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule